// File: doc/BRIEF.md
# Choice-of-Joins Handshake Composite

This block is a transition-signalling composite with four request inputs `a`, `b`, `c`, `d` and one completion output `z`. Every level change on a wire is one event. In the default arrangement the environment finishes a round in one of two ways: it toggles both `a` and `b`, in any order, or it toggles both `c` and `d`, in any order. It then waits until `z` toggles before it begins the next round. Rounds repeat without limit.

The inner structure is a two-level tree of three operator cells. The left cell combines `a` and `b` into a hidden event stream. The right cell combines `c` and `d` into a second hidden stream. The top cell combines the two hidden streams into `z`. Each of the three positions is chosen by its own parameter. A join position becomes a two-input Muller C-element, which emits one event after both of its inputs have produced an event. A choice position becomes a merge, which emits one event for each input event. The hidden streams are not visible at the ports.

Input levels are captured by a clocked two-stage sampler. Events are found by comparing the two stages. A protocol monitor tracks the current round from the input events and from `z`. It raises a sticky flag when the environment breaks the handshake.

Top module: `hs_choice_join`

## Requirements
- R1: While `rst_n` is low, `z` and `proto_err` are 0. After reset, no join cell holds a pending event, and all sampled input levels are 0.
- R2: Default configuration (left join, top choice, right join): when `a` and `b` each toggle once, in either order, `z` toggles exactly once. The toggle happens at the second rising clock edge after the toggle that completes the pair.
- R3: Default configuration: when `c` and `d` each toggle once, in either order, `z` toggles exactly once, with the same latency as in R2.
- R4: A single toggle on one input of a join pair leaves `z` unchanged. The join cell keeps that event pending until its partner arrives.
- R5: When both inputs of a join pair toggle between the same two clock edges, `z` toggles exactly once.
- R6: A choice position emits one output event for each input event. With the left position set to choice, a toggle on `a` alone toggles `z`, and a later toggle on `b` alone toggles `z` again.
- R7: With the top position set to join, `z` toggles only after both the left group and the right group have completed.
- R8: `proto_err` rises when one round takes inputs from both sides of a choice position. Example: `a` and then `c` in the default configuration.
- R9: `proto_err` rises when an input toggles a second time within one round, before `z` has answered.
- R10: `proto_err` rises when an input toggles while `z` is pending. Pending means the round has completed but the change on `z` has not yet been seen; in practice this is a toggle in the clock cycle right after the completing input was sampled.
- R11: `proto_err` stays high until reset.
- R12: Any number of consecutive legal rounds, each started after `z` has answered, leaves `proto_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 1 | Left group, first request level |
| b | input | 1 | Left group, second request level |
| c | input | 1 | Right group, first request level |
| d | input | 1 | Right group, second request level |
| z | output | 1 | Completion level; toggles once per finished round |
| proto_err | output | 1 | Sticky handshake violation flag |

## Verification
The bench builds three instances.

- The default instance (join, choice, join) carries the vector table, randomly ordered legal rounds, simultaneous pair arrival, and every violation case.
- An all-join instance makes R7 reachable, where both groups must complete before `z` answers.
- An instance with the left position and the top position set to choice (right stays join) exercises the merge behaviour of R6 on a single input and shows that one configuration can mix a merge side with a join side.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    OP_CHOICE = 1'b0,
    OP_JOIN   = 1'b1
  } op_kind_e;

  localparam int unsigned N_IN   = 4;
  localparam int unsigned N_SIDE = 2;
endpackage

// File: rtl/hs_level_sampler.sv
module hs_level_sampler #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] ev
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [W-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = din;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign ev = stage1_q ^ stage2_q;
endmodule

// File: rtl/hs_join_cell.sv
module hs_join_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_x,
  input  logic ev_y,
  output logic out_ev,
  output logic out_lvl
);
  logic pend_x_q, pend_y_q, lvl_q;
  logic pend_x_d, pend_y_d, lvl_d;
  logic got_x, got_y, fire, upd;

  always_comb begin
    got_x    = pend_x_q | ev_x;
    got_y    = pend_y_q | ev_y;
    fire     = got_x & got_y;
    upd      = ev_x | ev_y;
    pend_x_d = got_x & ~fire;
    pend_y_d = got_y & ~fire;
    lvl_d    = lvl_q ^ fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_x_q <= 1'b0;
      pend_y_q <= 1'b0;
      lvl_q    <= 1'b0;
    end else if (upd) begin
      pend_x_q <= pend_x_d;
      pend_y_q <= pend_y_d;
      lvl_q    <= lvl_d;
    end
  end

  assign out_ev  = fire;
  assign out_lvl = lvl_q;
endmodule

// File: rtl/hs_merge_cell.sv
module hs_merge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_x,
  input  logic ev_y,
  output logic out_ev,
  output logic out_lvl
);
  logic lvl_q, lvl_d, fire;

  always_comb begin
    fire  = ev_x ^ ev_y;
    lvl_d = ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (fire) begin
      lvl_q <= lvl_d;
    end
  end

  assign out_ev  = fire;
  assign out_lvl = lvl_q;
endmodule

// File: rtl/hs_op_cell.sv
module hs_op_cell
  import hs_pkg::*;
#(
  parameter op_kind_e KIND = OP_JOIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_x,
  input  logic ev_y,
  output logic out_ev,
  output logic out_lvl
);
  generate
    if (KIND == OP_JOIN) begin : g_join
      hs_join_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_x   (ev_x),
        .ev_y   (ev_y),
        .out_ev (out_ev),
        .out_lvl(out_lvl)
      );
    end else begin : g_merge
      hs_merge_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_x   (ev_x),
        .ev_y   (ev_y),
        .out_ev (out_ev),
        .out_lvl(out_lvl)
      );
    end
  endgenerate
endmodule

// File: rtl/hs_round_monitor.sv
module hs_round_monitor
  import hs_pkg::*;
#(
  parameter op_kind_e OP_L   = OP_JOIN,
  parameter op_kind_e OP_TOP = OP_CHOICE,
  parameter op_kind_e OP_R   = OP_JOIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_ev,
  input  logic            z,
  output logic            err
);
  logic [N_IN-1:0] seen_q, seen_d, all_seen;
  logic            pend_q, pend_d, zq, err_q, err_d;
  logic            z_ev, any_ev, rep, l_hit, r_hit;
  logic            bad_l, bad_r, bad_mix, l_done, r_done, done, viol;

  always_comb begin
    z_ev     = z ^ zq;
    any_ev   = |in_ev;
    all_seen = seen_q | in_ev;
    rep      = |(seen_q & in_ev);
    l_hit    = all_seen[0] | all_seen[1];
    r_hit    = all_seen[2] | all_seen[3];
    bad_l    = (OP_L == OP_CHOICE) && all_seen[0] && all_seen[1];
    bad_r    = (OP_R == OP_CHOICE) && all_seen[2] && all_seen[3];
    bad_mix  = (OP_TOP == OP_CHOICE) && l_hit && r_hit;
    l_done   = (OP_L == OP_JOIN) ? (all_seen[0] & all_seen[1]) : l_hit;
    r_done   = (OP_R == OP_JOIN) ? (all_seen[2] & all_seen[3]) : r_hit;
    done     = (OP_TOP == OP_JOIN) ? (l_done & r_done) : (l_done | r_done);
    viol     = pend_q ? any_ev : (rep | bad_l | bad_r | bad_mix);
    err_d    = err_q | viol;

    seen_d = seen_q;
    pend_d = pend_q;
    if (pend_q) begin
      if (z_ev) pend_d = 1'b0;
    end else if (any_ev) begin
      if (done) begin
        seen_d = '0;
        pend_d = 1'b1;
      end else begin
        seen_d = all_seen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      pend_q <= 1'b0;
      zq     <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      pend_q <= pend_d;
      zq     <= z;
      err_q  <= err_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/hs_choice_join.sv
module hs_choice_join
  import hs_pkg::*;
#(
  parameter op_kind_e OP_L   = OP_JOIN,
  parameter op_kind_e OP_TOP = OP_CHOICE,
  parameter op_kind_e OP_R   = OP_JOIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic z,
  output logic proto_err
);
  logic [N_IN-1:0] in_lvl, in_ev;
  logic            y1_ev, y2_ev, y1_lvl, y2_lvl, z_ev;

  assign in_lvl = {d, c, b, a};

  hs_level_sampler #(.W(N_IN)) u_smp (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (in_lvl),
    .ev   (in_ev)
  );

  hs_op_cell #(.KIND(OP_L)) u_left (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_x   (in_ev[0]),
    .ev_y   (in_ev[1]),
    .out_ev (y1_ev),
    .out_lvl(y1_lvl)
  );

  hs_op_cell #(.KIND(OP_R)) u_right (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_x   (in_ev[2]),
    .ev_y   (in_ev[3]),
    .out_ev (y2_ev),
    .out_lvl(y2_lvl)
  );

  hs_op_cell #(.KIND(OP_TOP)) u_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_x   (y1_ev),
    .ev_y   (y2_ev),
    .out_ev (z_ev),
    .out_lvl(z)
  );

  hs_round_monitor #(.OP_L(OP_L), .OP_TOP(OP_TOP), .OP_R(OP_R)) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .in_ev(in_ev),
    .z    (z),
    .err  (proto_err)
  );
endmodule

// File: rtl/hs_choice_join_chk.sv
module hs_choice_join_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] in_ev,
  input logic       y1,
  input logic       y2,
  input logic       z,
  input logic       z_ev,
  input logic       proto_err
);
  // R1: outputs low throughout reset
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> (!z && !proto_err));

  // R2: a change on z always comes with a change on one hidden side level
  a_r2_z_from_side: assert property (@(posedge clk) disable iff (!rst_n)
    (z != $past(z)) |-> ((y1 != $past(y1)) || (y2 != $past(y2))));

  // R4: the left side level changes only on a sampled a or b event
  a_r4_left_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (y1 != $past(y1)) |-> $past(in_ev[0] | in_ev[1]));

  // R9: the error flag rises only after some sampled input event
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(|in_ev));

  // R11: the error flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R2: the top event and the z level agree one edge later
  a_r2_top_event_flips: assert property (@(posedge clk) disable iff (!rst_n)
    z_ev |=> (z != $past(z)));
endmodule

bind hs_choice_join hs_choice_join_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ev    (in_ev),
  .y1       (y1_lvl),
  .y2       (y2_lvl),
  .z        (z),
  .z_ev     (z_ev),
  .proto_err(proto_err)
);

// File: tb/hs_choice_join_test.sv
`timescale 1ns/1ps
module hs_choice_join_test;
  import hs_pkg::*;

  logic       clk;
  logic       rst_n;
  logic [3:0] in0, in1, in2;
  logic       z0, z1, z2, e0, e1, e2;
  int         n_checks, n_fail;
  logic       ez;
  bit         finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hs_choice_join uut (
    .clk(clk), .rst_n(rst_n),
    .a(in0[0]), .b(in0[1]), .c(in0[2]), .d(in0[3]),
    .z(z0), .proto_err(e0)
  );

  hs_choice_join #(.OP_L(OP_JOIN), .OP_TOP(OP_JOIN), .OP_R(OP_JOIN)) uut_all_join (
    .clk(clk), .rst_n(rst_n),
    .a(in1[0]), .b(in1[1]), .c(in1[2]), .d(in1[3]),
    .z(z1), .proto_err(e1)
  );

  hs_choice_join #(.OP_L(OP_CHOICE), .OP_TOP(OP_CHOICE), .OP_R(OP_JOIN)) uut_merge_left (
    .clk(clk), .rst_n(rst_n),
    .a(in2[0]), .b(in2[1]), .c(in2[2]), .d(in2[3]),
    .z(z2), .proto_err(e2)
  );

  // {first input index, second input index, expected z after the round}
  localparam logic [4:0] VEC [8] = '{
    {2'd0, 2'd1, 1'b1}, {2'd1, 2'd0, 1'b0}, {2'd2, 2'd3, 1'b1}, {2'd3, 2'd2, 1'b0},
    {2'd0, 2'd1, 1'b1}, {2'd3, 2'd2, 1'b0}, {2'd2, 2'd3, 1'b1}, {2'd1, 2'd0, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in0 = '0; in1 = '0; in2 = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; finished = 1'b0;
    in0 = '0; in1 = '0; in2 = '0;
    rst_n = 1'b0;
    step(1);
    // R1: state while reset is applied
    check("R1 z in reset", z0, 1'b0);
    check("R1 err in reset", e0, 1'b0);
    do_reset();

    // R2 / R3 / R4: vector table walk
    ez = 1'b0;
    foreach (VEC[i]) begin
      in0[VEC[i][4:3]] = ~in0[VEC[i][4:3]];
      step(2);
      check("R4 half pair holds z", z0, ez);
      in0[VEC[i][2:1]] = ~in0[VEC[i][2:1]];
      step(2);
      ez = VEC[i][0];
      check((VEC[i][4:3] < 2) ? "R2 left pair" : "R3 right pair", z0, ez);
    end

    // R12: random legal rounds
    for (int r = 0; r < 24; r++) begin
      int g, o;
      g = $urandom_range(1, 0);
      o = $urandom_range(1, 0);
      in0[g*2 + o] = ~in0[g*2 + o];
      step(1);
      in0[g*2 + 1 - o] = ~in0[g*2 + 1 - o];
      step(2);
      ez = ~ez;
      check("R12 random round z", z0, ez);
    end
    check("R12 no error after legal rounds", e0, 1'b0);

    // R5: both join inputs within one sample
    in0[2] = ~in0[2]; in0[3] = ~in0[3];
    step(2);
    ez = ~ez;
    check("R5 simultaneous pair", z0, ez);
    step(2);
    check("R5 single toggle only", z0, ez);
    check("R5 no error", e0, 1'b0);

    // R8: mixing groups
    in0[0] = ~in0[0];
    step(1);
    in0[2] = ~in0[2];
    step(3);
    check("R8 mixed groups flag", e0, 1'b1);

    // R11: sticky through legal activity
    in0[1] = ~in0[1];
    step(3);
    in0[3] = ~in0[3];
    step(5);
    check("R11 flag stays high", e0, 1'b1);
    do_reset();
    check("R1 z after reset", z0, 1'b0);
    check("R11 flag cleared by reset", e0, 1'b0);

    // R9: repeated input before z
    in0[0] = 1'b1;
    step(1);
    in0[0] = 1'b0;
    step(3);
    check("R9 repeat flag", e0, 1'b1);
    check("R9 z unchanged", z0, 1'b0);
    do_reset();

    // R10: toggle in the cycle while z is pending
    in0[0] = 1'b1;
    step(1);
    in0[1] = 1'b1;
    step(1);
    in0[2] = 1'b1;
    step(3);
    check("R10 z answered", z0, 1'b1);
    check("R10 pending toggle flag", e0, 1'b1);
    do_reset();

    // R7: all-join instance needs both groups
    in1[0] = 1'b1; step(1); in1[1] = 1'b1; step(3);
    check("R7 left only holds z", z1, 1'b0);
    in1[3] = 1'b1; step(1); in1[2] = 1'b1; step(2);
    check("R7 both groups toggle z", z1, 1'b1);
    check("R7 no error", e1, 1'b0);

    // R6: merge on the left position
    in2[0] = 1'b1; step(2);
    check("R6 a alone toggles z", z2, 1'b1);
    in2[1] = 1'b1; step(2);
    check("R6 b alone toggles z", z2, 1'b0);
    in2[2] = 1'b1; step(1); in2[3] = 1'b1; step(2);
    check("R6 join side with merge top", z2, 1'b1);
    check("R6 no error", e2, 1'b0);

    finish_run();
  end
endmodule